// File: doc/BRIEF.md
# Supervisory Reset Sequencer

This block decides when a system is held in reset. It watches three things: a supply-good flag from an external comparator, an active-low pushbutton, and the sensed level of a shared reset line that other devices may also pull low. Its one registered output drives both a reset level for local logic and the pull-down enable of an open-drain pad on that shared line.

Reset holds while the supply is bad or the button is pressed. When both have cleared, reset stays on for a fixed stretch. A falling edge on the shared line also starts a full stretch, however short the external pulse is. Brief dips on the supply flag and brief presses of the button are filtered out. The shared line's own fall, caused when this block starts pulling it low, is masked so that it cannot retrigger the block. All durations are parameters counted in clock cycles. On reset the block comes up asserted.

Top module: `rst_sequencer`

## Requirements
- R1: After the asynchronous reset is released, `rst_level_o` is 1, and it stays 1 until the supply has been good for the full stretch.
- R2: When `supply_ok_i` is sampled low on SUP_FILT_CYC consecutive clock edges, `rst_level_o` is 1 from the following cycle on and stays 1 while the supply is still low.
- R3: A low run on `supply_ok_i` shorter than SUP_FILT_CYC edges leaves `rst_level_o` at 0.
- R4: Once the supply is good and no other source holds reset, `rst_level_o` stays 1 for exactly TIMEOUT_CYC more cycles and then goes to 0.
- R5: While the block is released, a falling edge on `pin_sense_i` (1 on one sampling edge, 0 on the next) sets `rst_level_o` to 1 for exactly TIMEOUT_CYC cycles, even if the line goes high again after one cycle.
- R6: Only the edge matters on the shared line. When the line is held low longer than the stretch, reset still releases after TIMEOUT_CYC cycles. The line rising again causes no new reset.
- R7: When `btn_n_i` is sampled low on BTN_FILT_CYC consecutive edges, reset is 1 from the next cycle on while the button stays low. After the button is released, reset stays 1 for TIMEOUT_CYC more cycles.
- R8: A button press shorter than BTN_FILT_CYC edges leaves `rst_level_o` at 0.
- R9: A new hold from the supply or the button during a running stretch restarts the count from zero. The output then stays 1 for TIMEOUT_CYC cycles after that hold ends.
- R10: The line falling because of this block's own pull-down does not start another stretch. After a stretch ends, the output stays at 0.
- R11: `pin_pull_o` equals `rst_level_o` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; puts the block in the asserted state |
| supply_ok_i | input | 1 | 1 when the supply is above threshold |
| btn_n_i | input | 1 | Manual reset button, 0 = pressed |
| pin_sense_i | input | 1 | Sensed level of the shared reset line, 0 = low |
| pin_pull_o | output | 1 | 1 = pull the shared line low |
| rst_level_o | output | 1 | 1 = reset asserted |

## Verification
The stretch counter can take a restart from a filtered hold (a supply dip or a button press) in the same cycle it would otherwise count or end the stretch. A supply dip of exactly the filter length is placed in the middle of a stretch that a button press started. The bench then checks that the stretch runs a full TIMEOUT_CYC cycles from the moment the supply recovers. A behavioural model compares `rst_level_o` against its own prediction on every clock, so a restart that is dropped or doubled shows up within one cycle.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  // width of a counter that must hold values 0..n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rsq_filter.sv
// Raises hit_o after act_i has been sampled high on LEN consecutive edges;
// drops it on the first edge act_i is low.
module rsq_filter #(
  parameter int unsigned LEN     = 4,
  parameter bit          RST_HIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  output logic hit_o
);
  localparam int unsigned CW = rsq_pkg::cnt_w(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] run_q, run_d;
  logic          hit_q, hit_d;

  always_comb begin
    run_d = run_q;
    hit_d = hit_q;
    if (!act_i) begin
      run_d = '0;
      hit_d = 1'b0;
    end else if (run_q == LAST) begin
      hit_d = 1'b1;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= RST_HIT ? LAST : '0;
      hit_q <= RST_HIT;
    end else begin
      run_q <= run_d;
      hit_q <= hit_d;
    end
  end

  assign hit_o = hit_q;
endmodule

// File: rtl/rsq_pin_edge.sv
// Falling-edge detector on the shared line, masked while this block drives it.
module rsq_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic own_drive_i,
  output logic fall_o
);
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_i;
  end

  assign fall_o = pin_q & ~pin_i & ~own_drive_i;
endmodule

// File: rtl/rsq_stretch.sv
// Holds act_o while hold_i is high or on trig_i, then for LEN more cycles.
module rsq_stretch #(
  parameter int unsigned LEN = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic trig_i,
  output logic act_o
);
  localparam int unsigned CW = rsq_pkg::cnt_w(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          cnt_en;

  assign cnt_en = act_q & ~hold_i & ~trig_i;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (hold_i || trig_i) begin
      cnt_d = '0;
      act_d = 1'b1;
    end else if (cnt_en) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int unsigned TIMEOUT_CYC  = 20,
  parameter int unsigned SUP_FILT_CYC = 3,
  parameter int unsigned BTN_FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic btn_n_i,
  input  logic pin_sense_i,
  output logic pin_pull_o,
  output logic rst_level_o
);
  logic sup_bad, btn_held, pin_fall, active;

  rsq_filter #(.LEN(SUP_FILT_CYC), .RST_HIT(1'b1)) u_sup_filt (
    .clk(clk), .rst_n(rst_n), .act_i(~supply_ok_i), .hit_o(sup_bad)
  );

  rsq_filter #(.LEN(BTN_FILT_CYC), .RST_HIT(1'b0)) u_btn_filt (
    .clk(clk), .rst_n(rst_n), .act_i(~btn_n_i), .hit_o(btn_held)
  );

  rsq_pin_edge u_pin_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_sense_i),
    .own_drive_i(active), .fall_o(pin_fall)
  );

  rsq_stretch #(.LEN(TIMEOUT_CYC)) u_stretch (
    .clk(clk), .rst_n(rst_n), .hold_i(sup_bad | btn_held),
    .trig_i(pin_fall), .act_o(active)
  );

  assign rst_level_o = active;
  assign pin_pull_o  = active;
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk #(
  parameter int unsigned SUP_FILT_CYC = 3,
  parameter int unsigned BTN_FILT_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok_i,
  input logic btn_n_i,
  input logic pin_sense_i,
  input logic pin_pull_o,
  input logic rst_level_o
);
  int unsigned sup_low_run, btn_low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_low_run <= 0;
      btn_low_run <= 0;
    end else begin
      if (supply_ok_i) sup_low_run <= 0;
      else if (sup_low_run < SUP_FILT_CYC) sup_low_run <= sup_low_run + 1;
      if (btn_n_i) btn_low_run <= 0;
      else if (btn_low_run < BTN_FILT_CYC) btn_low_run <= btn_low_run + 1;
    end
  end

  // R11: pad enable and reset level never disagree
  assert_pull_matches_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pull_o == rst_level_o);

  // R2: a filtered supply dip forces reset on the next cycle
  assert_supply_dip_resets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_low_run >= SUP_FILT_CYC) |=> rst_level_o);

  // R7: a filtered button press forces reset on the next cycle
  assert_button_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_low_run >= BTN_FILT_CYC) |=> rst_level_o);

  // R5: a line fall seen while released asserts reset at once
  assert_pin_fall_resets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_level_o && $past(pin_sense_i) && !pin_sense_i) |=> rst_level_o);
endmodule

bind rst_sequencer rst_sequencer_chk #(
  .SUP_FILT_CYC(SUP_FILT_CYC), .BTN_FILT_CYC(BTN_FILT_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok_i), .btn_n_i(btn_n_i),
  .pin_sense_i(pin_sense_i), .pin_pull_o(pin_pull_o), .rst_level_o(rst_level_o)
);

// File: tb/rst_sequencer_test.sv
`timescale 1ns/1ps
module rst_sequencer_test;
  localparam int T = 20;
  localparam int S = 3;
  localparam int B = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic btn_n = 1'b1;
  logic ext_low = 1'b0;
  logic pin_pull, rst_level, pin_sense;
  int total = 0;
  int bad = 0;

  assign pin_sense = ~(pin_pull | ext_low);

  always #2.5 clk = ~clk;

  rst_sequencer #(.TIMEOUT_CYC(T), .SUP_FILT_CYC(S), .BTN_FILT_CYC(B)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .btn_n_i(btn_n),
    .pin_sense_i(pin_sense), .pin_pull_o(pin_pull), .rst_level_o(rst_level)
  );

  // behavioural reference model
  int  m_srun, m_brun, m_cnt;
  bit  m_sbad, m_bheld, m_act, m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_srun = S; m_sbad = 1; m_brun = 0; m_bheld = 0;
      m_cnt = 0; m_act = 1; m_prev = 0;
    end else begin
      bit hold, fall;
      hold = m_sbad || m_bheld;
      fall = m_prev && !pin_sense && !m_act;
      if (hold || fall) begin
        m_cnt = 0; m_act = 1;
      end else if (m_act) begin
        if (m_cnt == T - 1) begin m_act = 0; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end
      m_prev = pin_sense;
      if (supply_ok) m_srun = 0; else m_srun = m_srun + 1;
      m_sbad = (m_srun >= S);
      if (btn_n) m_brun = 0; else m_brun = m_brun + 1;
      m_bheld = (m_brun >= B);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (rst_level !== m_act) begin
        bad++;
        $display("FAIL model R1-tracking: rst_level_o=%0b expected=%0b at %0t", rst_level, m_act, $time);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // count consecutive negedges with reset high; ext line released after ext_len
  task automatic measure(output int n, input int ext_len);
    n = 0;
    for (int k = 0; k < 4 * T; k++) begin
      @(negedge clk);
      if (k + 1 == ext_len) ext_low = 1'b0;
      if (rst_level) n++;
      else break;
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 level after reset", rst_level, 1);
    check("R11 pull after reset", pin_pull, 1);
    cycles(5);
    check("R1 held while supply low", rst_level, 1);

    supply_ok = 1'b1;
    measure(n, 0);
    check("R4 stretch after supply good", n, T);
    cycles(T);
    check("R10 no self retrigger after power-up", rst_level, 0);

    supply_ok = 1'b0; cycles(S - 1); supply_ok = 1'b1;
    cycles(5);
    check("R3 short supply dip ignored", rst_level, 0);

    supply_ok = 1'b0; cycles(10);
    check("R2 supply low asserts", rst_level, 1);
    check("R11 pull with supply low", pin_pull, 1);
    supply_ok = 1'b1;
    measure(n, 0);
    check("R4 stretch after dip", n, T);
    cycles(5);

    ext_low = 1'b1;
    measure(n, 1);
    check("R5 one-cycle line pulse gives full stretch", n, T);
    cycles(5);

    ext_low = 1'b1;
    measure(n, 2 * T);
    check("R6 long line low still releases", n, T);
    check("R6 pull released while line low", pin_pull, 0);
    cycles(T);
    ext_low = 1'b0;
    cycles(5);
    check("R6 line rising is no trigger", rst_level, 0);

    btn_n = 1'b0; cycles(B - 1); btn_n = 1'b1;
    cycles(5);
    check("R8 short press ignored", rst_level, 0);

    btn_n = 1'b0; cycles(10);
    check("R7 held button asserts", rst_level, 1);
    btn_n = 1'b1;
    measure(n, 0);
    check("R7 stretch after button release", n, T);
    cycles(2 * T);
    check("R10 own drive did not retrigger", rst_level, 0);

    btn_n = 1'b0; cycles(B + 2); btn_n = 1'b1;
    cycles(T / 2);
    check("R9 mid stretch", rst_level, 1);
    supply_ok = 1'b0; cycles(S); supply_ok = 1'b1;
    measure(n, 0);
    check("R9 restart from supply dip", n, T);
    cycles(5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule